// File: doc/BRIEF.md
# Reprogrammable Loop Tile

This block runs a software-pipelined loop kernel on three integer function units: an adder/subtracter, a left/right rotator and a multiplier. There is no fixed sequencer. A small control memory holds one wide word for each kernel slot. The host writes these words, and the literal constants, before a run. It then pulses `start` with the last slot index and an iteration count. The tile steps through slots `0..ii_last` over and over, once per iteration. Each slot's word alone decides what every unit computes, where each unit takes its operands from, whether the two operands are exchanged, where the result is written, what the shared bus carries, whether a stream word is consumed, and what is emitted on the output stream.

Each unit writes into its own rotating register file. Such a file is addressed by a logical index, which is offset by a base that steps forward at the end of every iteration. A value written in one iteration is therefore found one logical index lower in the next iteration. This lets a loop-carried value, such as a running sum, stay live across iterations without explicit move operations. A one-operand bus with one cycle of latency gives every unit access to any source. Loading a new set of words makes the same hardware run a different loop.

Top module: `loop_tile`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `in_take` and `out_valid` are low.
- R2: A `start` seen while idle begins a run. The run lasts `max(n_iter,1)` iterations of `ii_last+1` slots each, and `busy` stays high for exactly that many cycles. `done` is high for exactly one cycle, in the first cycle after the last slot, and `busy` is low in that cycle.
- R3: A control-memory write (`cm_we`) is stored at `cm_addr` only while idle. A write attempted during a run leaves the running program unchanged.
- R4: Operand selects use the following codes (defaults): 0–3 are unit 0 logical registers 0–3; 4–7 are unit 1; 8–11 are unit 2; 12–15 are literals 0–3; 16 is `in_data`; 17 is the bus register; any other code reads 0. The physical register is (logical + base) mod depth. The base is 0 at start and increases by 1 each time the slot counter wraps. `start` clears all register files and the bus register to 0.
- R5: Unit 0 opcodes: 1 gives A+B, 2 gives A−B, and 0 or 3 pass A unchanged (identity move). All results wrap modulo 2^16.
- R6: Unit 1 opcodes: 1 rotates A left by B mod 16, 2 rotates A right by B mod 16, and 0 or 3 pass A.
- R7: Unit 2 opcodes: 1 gives the low 16 bits of A×B, and 0, 2 or 3 pass A.
- R8: The swap bit of a unit exchanges its two selected operands before the operation, so that subtraction computes B−A.
- R9: Literals are written through `lit_we`/`lit_addr`/`lit_wdata` and are read through select codes 12–15.
- R10: When a slot sets the bus enable, the bus register captures the value of the bus select code at the end of that slot. From the next cycle on, select code 17 returns that value.
- R11: `in_take` is high in the slots whose take bit is set, and `in_data` is consumed in that cycle. `out_valid` is high in the slots whose output enable is set, and `out_data` then shows the value of the output select code.
- R12: A `start` pulse during a run is ignored. Control word layout, from the LSB: for each unit k, a 16-bit field at 16k made of {wen, dst[1:0], swap, srcB[4:0], srcA[4:0], op[1:0]}; then bus_en at bit 48, bus_src at 53:49, take at 54, out_en at 55 and out_src at 60:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_we | input | 1 | Control-memory write strobe |
| cm_addr | input | 2 | Slot index to write |
| cm_wdata | input | 61 | Control word |
| lit_we | input | 1 | Literal write strobe |
| lit_addr | input | 2 | Literal index |
| lit_wdata | input | 16 | Literal value |
| start | input | 1 | Begin a run |
| ii_last | input | 2 | Last slot index of the kernel |
| n_iter | input | 16 | Iteration count (0 is treated as 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| in_data | input | 16 | Input stream word |
| in_take | output | 1 | Input word consumed this cycle |
| out_data | output | 16 | Output stream word |
| out_valid | output | 1 | Output word valid this cycle |

## Verification
Three programs are loaded one after another. The first is a four-slot vector add that routes one operand through the bus. Its inputs include wrap-around sums, which separates a correct bus latency and adder from off-by-one timing. The second is a three-slot scaled accumulate. It multiplies by a literal and adds the product to the previous sum, which it reads back through the rotated index. Only correct base stepping and the clear on start yield the running sums. A mid-run start pulse and a control-memory write are aimed at this run. The third is a rotate-then-subtract program with swapped operands, run with shift amounts 0, 1, 7 and 15. It tells left rotation from right rotation and swapped subtraction from plain subtraction.

// File: rtl/loop_tile.sv
module loop_tile #(
  parameter int W     = 16,
  parameter int RRD   = 4,
  parameter int NLIT  = 4,
  parameter int SLOTS = 4,
  parameter int CNTW  = 16,
  localparam int NFU  = 3,
  localparam int RW   = $clog2(RRD),
  localparam int SAW  = $clog2(SLOTS),
  localparam int LAW  = $clog2(NLIT),
  localparam int SRC_LIT = NFU * RRD,
  localparam int SRC_IN  = SRC_LIT + NLIT,
  localparam int SRC_BUS = SRC_IN + 1,
  localparam int SELW = $clog2(SRC_BUS + 1),
  localparam int NSEL = 1 << SELW,
  localparam int FW   = 4 + 2 * SELW + RW,
  localparam int BUS_EN  = NFU * FW,
  localparam int BUS_SRC = BUS_EN + 1,
  localparam int TAKE    = BUS_SRC + SELW,
  localparam int OUT_EN  = TAKE + 1,
  localparam int OUT_SRC = OUT_EN + 1,
  localparam int CWW  = OUT_SRC + SELW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cm_we,
  input  logic [SAW-1:0]  cm_addr,
  input  logic [CWW-1:0]  cm_wdata,
  input  logic            lit_we,
  input  logic [LAW-1:0]  lit_addr,
  input  logic [W-1:0]    lit_wdata,
  input  logic            start,
  input  logic [SAW-1:0]  ii_last,
  input  logic [CNTW-1:0] n_iter,
  output logic            busy,
  output logic            done,
  input  logic [W-1:0]    in_data,
  output logic            in_take,
  output logic [W-1:0]    out_data,
  output logic            out_valid
);

  logic [CWW-1:0]  cmem [SLOTS];
  logic [W-1:0]    lits [NLIT];
  logic [W-1:0]    rf   [NFU][RRD];
  logic [W-1:0]    bus_q;
  logic [RW-1:0]   base;
  logic [SAW-1:0]  slot, last;
  logic [CNTW-1:0] iter, iters;
  logic [CWW-1:0]  cw;
  logic [W-1:0]    srcv [NSEL];
  logic [W-1:0]    fu_res [NFU];
  logic [RW-1:0]   fu_dst [NFU];
  logic            fu_wen [NFU];

  assign cw = cmem[slot];

  for (genvar i = 0; i < NSEL; i++) begin : g_src
    if (i < SRC_LIT) begin : g_rf
      localparam int F = i / RRD;
      localparam int L = i % RRD;
      assign srcv[i] = rf[F][RW'(L) + base];
    end else if (i < SRC_IN) begin : g_lit
      assign srcv[i] = lits[i - SRC_LIT];
    end else if (i == SRC_IN) begin : g_in
      assign srcv[i] = in_data;
    end else if (i == SRC_BUS) begin : g_bus
      assign srcv[i] = bus_q;
    end else begin : g_zero
      assign srcv[i] = '0;
    end
  end

  for (genvar k = 0; k < NFU; k++) begin : g_fu
    localparam int B0 = k * FW;
    logic [1:0]      op;
    logic [SELW-1:0] sa, sb;
    logic            swp;
    logic [W-1:0]    a, b;
    assign op  = cw[B0 +: 2];
    assign sa  = cw[B0 + 2 +: SELW];
    assign sb  = cw[B0 + 2 + SELW +: SELW];
    assign swp = cw[B0 + 2 + 2 * SELW];
    assign fu_dst[k] = cw[B0 + 3 + 2 * SELW +: RW];
    assign fu_wen[k] = cw[B0 + 3 + 2 * SELW + RW];
    assign a = swp ? srcv[sb] : srcv[sa];
    assign b = swp ? srcv[sa] : srcv[sb];
    if (k == 0) begin : g_add
      always_comb
        case (op)
          2'd1:    fu_res[k] = a + b;
          2'd2:    fu_res[k] = a - b;
          default: fu_res[k] = a;
        endcase
    end else if (k == 1) begin : g_rot
      logic [2*W-1:0] dl, dr;
      assign dl = {a, a} << (b % W);
      assign dr = {a, a} >> (b % W);
      always_comb
        case (op)
          2'd1:    fu_res[k] = dl[2*W-1:W];
          2'd2:    fu_res[k] = dr[W-1:0];
          default: fu_res[k] = a;
        endcase
    end else begin : g_mul
      assign fu_res[k] = (op == 2'd1) ? a * b : a;
    end
  end

  assign in_take   = busy & cw[TAKE];
  assign out_valid = busy & cw[OUT_EN];
  assign out_data  = srcv[cw[OUT_SRC +: SELW]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      slot  <= '0;
      last  <= '0;
      base  <= '0;
      iter  <= '0;
      iters <= '0;
      bus_q <= '0;
      for (int s = 0; s < SLOTS; s++) cmem[s] <= '0;
      for (int l = 0; l < NLIT; l++) lits[l] <= '0;
      for (int f = 0; f < NFU; f++)
        for (int r = 0; r < RRD; r++) rf[f][r] <= '0;
    end else begin
      done <= 1'b0;
      if (cm_we && !busy) cmem[cm_addr] <= cm_wdata;
      if (lit_we) lits[lit_addr] <= lit_wdata;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          slot  <= '0;
          base  <= '0;
          iter  <= '0;
          last  <= ii_last;
          iters <= (n_iter == '0) ? CNTW'(1) : n_iter;
          bus_q <= '0;
          for (int f = 0; f < NFU; f++)
            for (int r = 0; r < RRD; r++) rf[f][r] <= '0;
        end
      end else begin
        for (int f = 0; f < NFU; f++)
          if (fu_wen[f]) rf[f][fu_dst[f] + base] <= fu_res[f];
        if (cw[BUS_EN]) bus_q <= srcv[cw[BUS_SRC +: SELW]];
        if (slot == last) begin
          slot <= '0;
          base <= base + RW'(1);
          if (iter == iters - CNTW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            iter <= iter + CNTW'(1);
          end
        end else begin
          slot <= slot + SAW'(1);
        end
      end
    end
  end

  a_r3_cm_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cm_we) |=> (cmem[$past(cm_addr)] == $past(cmem[cm_addr])));
  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= last));
  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != last) |=> $stable(base));
  a_r4_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == last) |=> (base == RW'($past(base) + RW'(1))));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_stream_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take || out_valid) |-> busy);
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != last) |=> busy);

endmodule

// File: tb/loop_tile_test.sv
module loop_tile_test;
  localparam int CWW = 61;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cm_we = 1'b0;
  logic [1:0] cm_addr = '0;
  logic [CWW-1:0] cm_wdata = '0;
  logic lit_we = 1'b0;
  logic [1:0] lit_addr = '0;
  logic [15:0] lit_wdata = '0;
  logic start = 1'b0;
  logic [1:0] ii_last = '0;
  logic [15:0] n_iter = '0;
  logic busy, done, in_take, out_valid;
  logic [15:0] in_data, out_data;

  logic [15:0] stim [512];
  logic [15:0] got  [512];
  int sp = 0, ng = 0, bcyc = 0, dcnt = 0;
  int total = 0, fail = 0;

  always #5 clk = ~clk;

  loop_tile uut (
    .clk(clk), .rst_n(rst_n), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .lit_we(lit_we), .lit_addr(lit_addr), .lit_wdata(lit_wdata),
    .start(start), .ii_last(ii_last), .n_iter(n_iter), .busy(busy), .done(done),
    .in_data(in_data), .in_take(in_take), .out_data(out_data), .out_valid(out_valid)
  );

  assign in_data = stim[sp[8:0]];
  always @(posedge clk) if (in_take) sp <= sp + 1;
  always @(negedge clk) begin
    if (out_valid) begin got[ng[8:0]] = out_data; ng++; end
    if (busy) bcyc++;
    if (done) dcnt++;
  end

  function automatic logic [15:0] fu(input int op, input int sa, input int sb,
                                     input int sw, input int dst, input int wen);
    return {wen[0], dst[1:0], sw[0], sb[4:0], sa[4:0], op[1:0]};
  endfunction

  function automatic logic [CWW-1:0] word(input logic [15:0] f0, input logic [15:0] f1,
      input logic [15:0] f2, input int ben, input int bsrc, input int take,
      input int oen, input int osrc);
    return {osrc[4:0], oen[0], take[0], bsrc[4:0], ben[0], f2, f1, f0};
  endfunction

  function automatic logic [15:0] rotl(input logic [15:0] x, input int s);
    logic [31:0] d;
    d = {x, x} << s;
    return d[31:16];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmw(input int a, input logic [CWW-1:0] w);
    @(negedge clk); cm_we = 1'b1; cm_addr = a[1:0]; cm_wdata = w;
    @(negedge clk); cm_we = 1'b0;
  endtask

  task automatic litw(input int a, input int v);
    @(negedge clk); lit_we = 1'b1; lit_addr = a[1:0]; lit_wdata = v[15:0];
    @(negedge clk); lit_we = 1'b0;
  endtask

  int o0, b0, d0;

  task automatic run(input int nit, input int ilast, input bit poke);
    int guard;
    @(negedge clk);
    o0 = ng; b0 = bcyc; d0 = dcnt;
    ii_last = ilast[1:0]; n_iter = nit[15:0]; start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!done && guard < 3000) begin
      if (poke && guard == 4) begin
        start = 1'b1; n_iter = 16'd1; cm_we = 1'b1; cm_addr = 2'd2; cm_wdata = '0;
      end else begin
        start = 1'b0; cm_we = 1'b0;
      end
      @(negedge clk); guard++;
    end
    start = 1'b0; cm_we = 1'b0;
    if (guard >= 3000) chk(1'b0, "R2 run never finished", guard, 0);
    @(negedge clk); #1;
  endtask

  initial begin
    #1000000;
    chk(1'b0, "R2 watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end

  initial begin
    logic [15:0] av [8];
    logic [15:0] bv [8];
    logic [15:0] acc;
    int shv [4];
    int k;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !out_valid && !in_take, "R1 outputs during reset",
        {busy, done, out_valid, in_take}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid && !in_take, "R1 outputs after reset",
        {busy, done, out_valid, in_take}, 0);

    // Program 1: vector add through the bus (R5 R10 R11)
    cmw(0, word(fu(0,0,0,0,0,0), fu(0,16,0,0,0,1), fu(0,0,0,0,0,0), 0, 0, 1, 0, 0));
    cmw(1, word(fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), 1, 16, 1, 0, 0));
    cmw(2, word(fu(1,4,17,0,0,1), fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), 0, 0, 0, 0, 0));
    cmw(3, word(fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), 0, 0, 0, 1, 0));
    for (int j = 0; j < 8; j++) begin
      av[j] = 16'(j * 16'h1111);
      bv[j] = (j == 7) ? 16'h8889 : 16'(16'h0F0F ^ (j << 3));
      stim[(sp + 2*j) % 512] = av[j];
      stim[(sp + 2*j + 1) % 512] = bv[j];
    end
    run(8, 3, 1'b0);
    chk(ng - o0 == 8, "R11 vector add output count", ng - o0, 8);
    chk(bcyc - b0 == 32, "R2 busy cycles 8x4", bcyc - b0, 32);
    chk(dcnt - d0 == 1, "R2 done pulse width", dcnt - d0, 1);
    for (int j = 0; j < 8; j++)
      chk(got[(o0 + j) % 512] == 16'(av[j] + bv[j]), "R5 R10 vector add sum",
          got[(o0 + j) % 512], 16'(av[j] + bv[j]));

    stim[sp % 512] = 16'h1234; stim[(sp + 1) % 512] = 16'h0101;
    run(0, 3, 1'b0);
    chk(ng - o0 == 1, "R2 n_iter zero runs once", ng - o0, 1);
    chk(got[o0 % 512] == 16'h1335, "R2 n_iter zero result", got[o0 % 512], 16'h1335);

    // Program 2: scaled accumulate with carried sum (R4 R7 R8 R9 R3 R12)
    litw(0, 16'h0101);
    cmw(0, word(fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), fu(1,16,12,0,0,1), 0, 0, 1, 0, 0));
    cmw(1, word(fu(1,8,3,1,0,1), fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), 0, 0, 0, 0, 0));
    cmw(2, word(fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), 0, 0, 0, 1, 0));
    cmw(3, '0);
    for (int j = 0; j < 9; j++) stim[(sp + j) % 512] = 16'(j * 16'h0731 + 16'h00F3);
    run(9, 2, 1'b1);
    chk(ng - o0 == 9, "R3 R12 run unaffected by poke (outputs)", ng - o0, 9);
    chk(bcyc - b0 == 27, "R12 busy cycles 9x3", bcyc - b0, 27);
    acc = 16'h0;
    for (int j = 0; j < 9; j++) begin
      acc = 16'(acc + 16'(16'(j * 16'h0731 + 16'h00F3) * 16'h0101));
      chk(got[(o0 + j) % 512] == acc, "R4 R7 R9 running sum", got[(o0 + j) % 512], acc);
    end

    // Program 3: rotate then swapped subtract (R6 R8)
    litw(2, 16'hA5C3);
    cmw(0, word(fu(0,0,0,0,0,0), fu(1,16,13,0,0,1), fu(0,0,0,0,0,0), 0, 0, 1, 0, 0));
    cmw(1, word(fu(2,4,14,1,0,1), fu(2,4,13,0,1,1), fu(0,0,0,0,0,0), 0, 0, 0, 0, 0));
    cmw(2, word(fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), 0, 0, 0, 1, 0));
    cmw(3, word(fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), fu(0,0,0,0,0,0), 0, 0, 0, 1, 5));
    shv[0] = 0; shv[1] = 1; shv[2] = 7; shv[3] = 15;
    for (int m = 0; m < 4; m++) begin
      litw(1, shv[m]);
      for (int j = 0; j < 3; j++) stim[(sp + j) % 512] = 16'(16'h8001 + j * 16'h1357);
      run(3, 3, 1'b0);
      chk(ng - o0 == 6, "R11 rotate program output count", ng - o0, 6);
      for (int j = 0; j < 3; j++) begin
        k = o0 + 2 * j;
        chk(got[k % 512] == 16'(16'hA5C3 - rotl(16'(16'h8001 + j * 16'h1357), shv[m])),
            "R6 R8 swapped sub of left rotate", got[k % 512],
            16'(16'hA5C3 - rotl(16'(16'h8001 + j * 16'h1357), shv[m])));
        chk(got[(k + 1) % 512] == 16'(16'h8001 + j * 16'h1357), "R6 right rotate restores",
            got[(k + 1) % 512], 16'(16'h8001 + j * 16'h1357));
      end
    end
    chk(!busy && !out_valid && !in_take, "R1 idle after runs", {busy, out_valid, in_take}, 0);

    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end
endmodule